// File: doc/BRIEF.md
# Debug Command Decoder with Processor Halt and Reset Control

This block sits behind the data register of a JTAG test access port and reads every scan a debugger delivers. The last bit shifted in marks the kind of scan. A scan whose last bit is 1 chooses which of four debug modules later scans will address. A scan whose last bit is 0 is a command for the module chosen earlier. That choice is held across any number of scans, until another module-select scan or a TAP reset replaces it.

Each processor attached to the debug unit has its own control instance, built once per processor by a parameter. Each instance holds a register index and a small control register. Bit 0 of the control register halts the processor and bit 1 holds it in reset. A debugger picks the register index, writes the register with a payload placed ahead of the command, and reads the register back. To read it, the debugger shifts a no-operation command: the register value leaves on the serial output during that same scan, before the command bits go in.

Commands take effect on the update strobe. The shift register is loaded on the capture strobe and moves one bit toward the serial output on each shift cycle.

Top module: `dbg_cmd_sel`

## Requirements
- R1: While `rst_n` is low and after it is released, no module is selected (`sel_valid` = 0), all `cpu_halt` and `cpu_rst` bits are 0, and `tdo` is 0.
- R2: On each cycle with `shift_dr` high, the `tdi` bit enters at the top of an 8-bit shift register and `tdo` shows the bottom bit. At update, the command is read from the top bits, so the last bit shifted is the command flag.
- R3: A 3-bit scan {1, m[1:0]} selects module m at update: 0 = memory bus, 1 = processor 0, 2 = processor 1, 3 = serial port. `sel_valid` goes to 1 and `sel_module` to m. The selection holds across all later scans that are not module selects.
- R4: A one-cycle `tap_reset` pulse clears the selection (`sel_valid` = 0). It leaves processor control registers and register indexes unchanged.
- R5: The 6-bit scan {0, 4'hD, idx} sets the register index of the selected processor module to idx. The index holds until the next such command to that module.
- R6: The 8-bit scan {0, 4'h9, idx, p[1:0]} shifts the payload p first. At update it writes p into the selected processor's control register when that module's stored index is 0. Bit 0 drives `cpu_halt[n]` and bit 1 drives `cpu_rst[n]`.
- R7: At capture, when processor n's module is selected, bits 1:0 of the shift register are loaded with that module's control register if its index is 0, and with zero if its index is 1. All other bits are cleared. The first two `tdo` bits of the scan are therefore the register value. With no processor module selected, `tdo` reads 0 throughout. The no-operation opcode 4'h0 changes no state.
- R8: Module commands with an opcode other than 4'h0, 4'h9 or 4'hD change no state.
- R9: A module command reaches only the selected processor module. The other processor, and the case where nothing is selected or a non-processor module is selected, see no change.
- R10: A write while the selected module's index is 1 is ignored. The control register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tap_reset | input | 1 | TAP logic-reset pulse; clears module selection |
| capture_dr | input | 1 | Capture strobe; loads read data into the shift register |
| shift_dr | input | 1 | Shift enable |
| update_dr | input | 1 | Update strobe; applies the shifted command |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bottom of shift register) |
| sel_valid | output | 1 | A module is currently selected |
| sel_module | output | 2 | Number of the selected module |
| cpu_halt | output | N_CPU | Halt request per processor |
| cpu_rst | output | N_CPU | Reset hold per processor |

## Verification
Directed scans first cover the separate cases:
- selecting each module kind;
- writing one processor and confirming the other is untouched;
- writing through index 1;
- unknown opcodes;
- commands sent with nothing selected;
- a TAP reset while a processor is halted.

These show whether a command is steered by the latched selection or leaks to a neighbour. A seeded random run then mixes module selects, index selects, writes, reads, unknown opcodes and TAP resets in arbitrary orders. The random run checks two things against a bench model after every scan. First, the two read bits that lead every scan must match the register and index of whichever processor was selected at capture. Second, `sel_valid`, `sel_module`, `cpu_halt` and `cpu_rst` must match the model. The random mix separates errors in bit order or field position from errors in which state a command reaches.

// File: rtl/dbgsel_pkg.sv
package dbgsel_pkg;

  localparam int MODSEL_W = 2;
  localparam int OPC_W    = 4;
  localparam int IDX_W    = 1;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP    = 4'h0,
    OPC_REGWR  = 4'h9,
    OPC_REGSEL = 4'hD
  } opcode_e;

  typedef enum logic [MODSEL_W-1:0] {
    MOD_MEMBUS = 2'd0,
    MOD_CPU0   = 2'd1,
    MOD_CPU1   = 2'd2,
    MOD_SERIAL = 2'd3
  } module_e;

endpackage

// File: rtl/dbgsel_rst_sync.sv
module dbgsel_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/dbgsel_shift.sv
module dbgsel_shift #(
  parameter int SR_W   = 8,
  parameter int LOAD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic [LOAD_W-1:0] load_val,
  output logic [SR_W-1:0]   sr,
  output logic              tdo
);
  logic [SR_W-1:0] sr_q, sr_d;
  logic            sr_en;

  always_comb begin
    sr_en = capture | shift;
    sr_d  = sr_q;
    if (capture)    sr_d = {{(SR_W-LOAD_W){1'b0}}, load_val};
    else if (shift) sr_d = {tdi, sr_q[SR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sr  = sr_q;
  assign tdo = sr_q[0];

  // R2: a shifted bit lands at the top of the register
  assert_shift_in_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !capture) |=> (sr_q[SR_W-1] == $past(tdi)));

  // R7: capture places the read value at the output end
  assert_capture_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (sr_q[LOAD_W-1:0] == $past(load_val)));
endmodule

// File: rtl/dbgsel_decode.sv
module dbgsel_decode
  import dbgsel_pkg::*;
#(
  parameter int SR_W   = 8,
  parameter int N_CPU  = 2,
  parameter int CTRL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tap_reset,
  input  logic                update,
  input  logic [SR_W-1:0]     sr,
  output logic                sel_valid,
  output logic [MODSEL_W-1:0] sel_module,
  output logic [N_CPU-1:0]    regsel_stb,
  output logic [N_CPU-1:0]    regwr_stb,
  output logic                cmd_idx,
  output logic [CTRL_W-1:0]   cmd_payload
);
  localparam int FLAG_POS = SR_W - 1;
  localparam int OPC_TOP  = SR_W - 2;
  localparam int IDX_POS  = SR_W - 2 - OPC_W;

  logic                flag_f;
  logic [MODSEL_W-1:0] mod_f;
  logic [OPC_W-1:0]    opc_f;

  logic                sel_valid_q, sel_valid_d;
  logic [MODSEL_W-1:0] sel_module_q, sel_module_d;
  logic                sel_en;

  assign flag_f      = sr[FLAG_POS];
  assign mod_f       = sr[OPC_TOP -: MODSEL_W];
  assign opc_f       = sr[OPC_TOP -: OPC_W];
  assign cmd_idx     = sr[IDX_POS];
  assign cmd_payload = sr[CTRL_W-1:0];

  always_comb begin
    sel_en       = tap_reset | (update & flag_f);
    sel_valid_d  = !tap_reset;
    sel_module_d = tap_reset ? '0 : mod_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid_q  <= 1'b0;
      sel_module_q <= '0;
    end else if (sel_en) begin
      sel_valid_q  <= sel_valid_d;
      sel_module_q <= sel_module_d;
    end
  end

  always_comb begin
    for (int i = 0; i < N_CPU; i++) begin
      regsel_stb[i] = 1'b0;
      regwr_stb[i]  = 1'b0;
      if (update && !flag_f && !tap_reset && sel_valid_q &&
          sel_module_q == MODSEL_W'(i + 1)) begin
        regsel_stb[i] = (opc_f == OPC_REGSEL);
        regwr_stb[i]  = (opc_f == OPC_REGWR);
      end
    end
  end

  assign sel_valid  = sel_valid_q;
  assign sel_module = sel_module_q;

  // R4: a TAP reset leaves no module selected
  assert_tapreset_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tap_reset |=> !sel_valid_q);

  // R3: a module-select scan latches the number it carried
  assert_select_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (update && flag_f && !tap_reset) |=> (sel_valid_q && sel_module_q == $past(mod_f)));

  // R3: selection persists when neither strobe is present
  assert_select_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!update && !tap_reset) |=> ($stable(sel_valid_q) && $stable(sel_module_q)));

  // R9: at most one processor module sees a command
  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(regsel_stb | regwr_stb));
endmodule

// File: rtl/dbgsel_cpu_ctrl.sv
module dbgsel_cpu_ctrl #(
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_stb,
  input  logic              wr_stb,
  input  logic              cmd_idx,
  input  logic [CTRL_W-1:0] payload,
  output logic [CTRL_W-1:0] rd_val,
  output logic              halt,
  output logic              hold_rst
);
  logic              idx_q, idx_d, idx_en;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  always_comb begin
    idx_en  = sel_stb;
    idx_d   = cmd_idx;
    ctrl_en = wr_stb && (idx_q == 1'b0);
    ctrl_d  = payload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= 1'b0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign rd_val   = (idx_q == 1'b0) ? ctrl_q : '0;
  assign halt     = ctrl_q[0];
  assign hold_rst = ctrl_q[1];

  // R5: the index changes only on a register-select command
  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_stb |=> $stable(idx_q));

  // R8: no write strobe, no change of the control register
  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(ctrl_q));

  // R10: writes through index 1 are dropped
  assert_idx1_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && idx_q) |=> $stable(ctrl_q));

  // R6: a write through index 0 stores the payload
  assert_write_stores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !idx_q) |=> (ctrl_q == $past(payload)));
endmodule

// File: rtl/dbg_cmd_sel.sv
module dbg_cmd_sel
  import dbgsel_pkg::*;
#(
  parameter int N_CPU  = 2,
  parameter int CTRL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tap_reset,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                tdi,
  output logic                tdo,
  output logic                sel_valid,
  output logic [MODSEL_W-1:0] sel_module,
  output logic [N_CPU-1:0]    cpu_halt,
  output logic [N_CPU-1:0]    cpu_rst
);
  localparam int SR_W = 1 + OPC_W + IDX_W + CTRL_W;

  logic                          rst_sync_n;
  logic [SR_W-1:0]               sr;
  logic [N_CPU-1:0]              regsel_stb, regwr_stb;
  logic                          cmd_idx;
  logic [CTRL_W-1:0]             cmd_payload;
  logic [N_CPU-1:0][CTRL_W-1:0]  rd_val;
  logic [CTRL_W-1:0]             load_val;

  dbgsel_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dbgsel_shift #(.SR_W(SR_W), .LOAD_W(CTRL_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .capture  (capture_dr),
    .shift    (shift_dr),
    .tdi      (tdi),
    .load_val (load_val),
    .sr       (sr),
    .tdo      (tdo)
  );

  dbgsel_decode #(.SR_W(SR_W), .N_CPU(N_CPU), .CTRL_W(CTRL_W)) u_decode (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tap_reset   (tap_reset),
    .update      (update_dr),
    .sr          (sr),
    .sel_valid   (sel_valid),
    .sel_module  (sel_module),
    .regsel_stb  (regsel_stb),
    .regwr_stb   (regwr_stb),
    .cmd_idx     (cmd_idx),
    .cmd_payload (cmd_payload)
  );

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    dbgsel_cpu_ctrl #(.CTRL_W(CTRL_W)) u_cpu_ctrl (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .sel_stb  (regsel_stb[g]),
      .wr_stb   (regwr_stb[g]),
      .cmd_idx  (cmd_idx),
      .payload  (cmd_payload),
      .rd_val   (rd_val[g]),
      .halt     (cpu_halt[g]),
      .hold_rst (cpu_rst[g])
    );
  end

  always_comb begin
    load_val = '0;
    for (int i = 0; i < N_CPU; i++) begin
      if (sel_valid && sel_module == MODSEL_W'(i + 1)) load_val = rd_val[i];
    end
  end

  // R8: module commands other than a write leave the processor outputs alone
  assert_nonwrite_stable_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (update_dr && !sr[SR_W-1] && sr[SR_W-2 -: OPC_W] != OPC_REGWR)
      |=> ($stable(cpu_halt) && $stable(cpu_rst)));

  // R1: outputs at rest while reset is held
  always_comb begin
    if (!rst_sync_n) begin
      assert_reset_state_R1: assert (!sel_valid && cpu_halt == '0 && cpu_rst == '0);
    end
  end
endmodule

// File: tb/dbg_cmd_sel_bench.sv
`timescale 1ns/1ps
module dbg_cmd_sel_bench;
  logic clk = 1'b0;
  logic rst_n, tap_reset, capture_dr, shift_dr, update_dr, tdi;
  logic tdo, sel_valid;
  logic [1:0] sel_module, cpu_halt, cpu_rst;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bit       m_valid;
  int       m_sel;
  bit [1:0] m_ctrl [2];
  bit       m_idx  [2];

  always #2 clk = ~clk;

  dbg_cmd_sel u_dbg_cmd_sel (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .sel_valid(sel_valid), .sel_module(sel_module),
    .cpu_halt(cpu_halt), .cpu_rst(cpu_rst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cur_cpu();
    if (m_valid && m_sel >= 1 && m_sel <= 2) return m_sel - 1;
    return -1;
  endfunction

  function automatic bit [1:0] exp_read();
    int c = cur_cpu();
    if (c < 0) return 2'b00;
    return m_idx[c] ? 2'b00 : m_ctrl[c];
  endfunction

  task automatic check_outputs(input string req);
    chk(req, "sel_valid", int'(sel_valid), int'(m_valid));
    if (m_valid) chk(req, "sel_module", int'(sel_module), m_sel);
    chk(req, "cpu_halt", int'(cpu_halt), int'({m_ctrl[1][0], m_ctrl[0][0]}));
    chk(req, "cpu_rst",  int'(cpu_rst),  int'({m_ctrl[1][1], m_ctrl[0][1]}));
  endtask

  // one full scan: capture, n shift cycles, update; returns bits seen on tdo
  task automatic scan(input int n, input bit [7:0] word);
    bit [7:0] got = '0;
    bit [1:0] er  = exp_read();
    @(negedge clk) capture_dr = 1'b1;
    @(negedge clk) capture_dr = 1'b0;
    for (int b = 0; b < n; b++) begin
      shift_dr = 1'b1; tdi = word[b]; got[b] = tdo;
      @(negedge clk);
    end
    shift_dr = 1'b0; tdi = 1'b0; update_dr = 1'b1;
    @(negedge clk) update_dr = 1'b0;
    chk("R7", "read bits", int'(got[1:0]), int'(er));
    if (n > 2) chk("R7", "upper read bits", int'(got[7:2]), 0);
  endtask

  task automatic do_select(input int m);
    scan(3, {5'b0, 1'b1, 2'(m)});
    m_valid = 1; m_sel = m;
    check_outputs("R3");
  endtask

  task automatic do_regsel(input bit idx);
    int c = cur_cpu();
    scan(6, {2'b0, 1'b0, 4'hD, idx});
    if (c >= 0) m_idx[c] = idx;
    check_outputs("R5");
  endtask

  task automatic do_cmd8(input bit [3:0] op, input bit idx, input bit [1:0] p, input string req);
    int c = cur_cpu();
    scan(8, {1'b0, op, idx, p});
    if (c >= 0 && op == 4'h9 && !m_idx[c]) m_ctrl[c] = p;
    if (c >= 0 && op == 4'hD) m_idx[c] = idx;
    check_outputs(req);
  endtask

  task automatic do_nop();
    scan(7, {1'b0, 1'b0, 4'h0, 2'b00});
    check_outputs("R7");
  endtask

  task automatic do_tap_reset();
    @(negedge clk) tap_reset = 1'b1;
    @(negedge clk) tap_reset = 1'b0;
    m_valid = 0;
    check_outputs("R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1: actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tap_reset = 0; capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    m_valid = 0; m_sel = 0;
    for (int i = 0; i < 2; i++) begin m_ctrl[i] = 0; m_idx[i] = 0; end
    repeat (3) @(negedge clk);
    check_outputs("R1");
    chk("R1", "tdo in reset", int'(tdo), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_outputs("R1");
    chk("R1", "tdo after reset", int'(tdo), 0);

    // R9: commands with nothing selected are dropped
    do_cmd8(4'h9, 1'b0, 2'b11, "R9");
    // R6: halt processor 0
    do_select(1);
    do_cmd8(4'h9, 1'b0, 2'b01, "R6");
    do_nop();
    // R3: selection persists over several scans
    do_nop();
    chk("R3", "sel persists", int'(sel_module), 1);
    // R6/R9: reset hold on processor 1, processor 0 untouched
    do_select(2);
    do_cmd8(4'h9, 1'b0, 2'b10, "R9");
    // R5/R10: index 1 reads zero, writes dropped
    do_regsel(1'b1);
    do_nop();
    do_cmd8(4'h9, 1'b1, 2'b01, "R10");
    do_regsel(1'b0);
    do_nop();
    // R8: unknown opcodes on processor 0
    do_select(1);
    do_cmd8(4'h3, 1'b0, 2'b10, "R8");
    do_cmd8(4'h7, 1'b1, 2'b11, "R8");
    do_cmd8(4'hF, 1'b0, 2'b00, "R8");
    // R9: memory bus and serial modules do not reach processors
    do_select(0);
    do_cmd8(4'h9, 1'b0, 2'b00, "R9");
    do_select(3);
    do_cmd8(4'hD, 1'b1, 2'b00, "R9");
    do_cmd8(4'h9, 1'b0, 2'b00, "R9");
    // R4: TAP reset keeps processor state
    do_select(1);
    do_tap_reset();
    do_cmd8(4'h9, 1'b0, 2'b00, "R4");
    do_nop();

    void'($urandom(32'h5EED));
    for (int it = 0; it < 300; it++) begin
      int kind = int'($urandom % 7);
      case (kind)
        0: do_select(int'($urandom % 4));
        1: do_regsel(1'($urandom));
        2, 3: do_cmd8(4'h9, 1'($urandom), 2'($urandom), "R6");
        4: do_nop();
        5: begin
          bit [3:0] op = 4'($urandom);
          if (op == 4'h0 || op == 4'h9 || op == 4'hD) op = 4'h5;
          do_cmd8(op, 1'($urandom), 2'($urandom), "R8");
        end
        default: do_tap_reset();
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule